// File: doc/BRIEF.md
# Function Unit Issue Manager

This block is the control shell around a small integer ALU in an out-of-order core. An issue stage hands it one operation with a single-cycle strobe. The block captures the opcode and its modifier fields, then fetches each source operand it needs from the register file. Each read port has its own request/acknowledge pair: the block raises a release, and the register file answers with a go pulse that carries the operand. Ports are skipped when the operation zeroes operand A, when an immediate stands in for operand B, or when the issue stage masks the port off.

Once every required operand has been latched, the block computes a 16-bit result and registers it. It then raises a write release and holds the result until a write-go pulse confirms that the result has been stored. A busy flag covers the whole span from acceptance to that confirmation. The issue stage therefore knows the unit is occupied, and no result can be lost.

Top module: `fu_issue_mgr`

## Requirements
- R1: After reset, `busy_o`, every bit of `rd_rel_o`, `wr_rel_o` and `result_o` are all zero.
- R2: An issue is accepted only when `issue_i` is high and `busy_o` is low. `busy_o` rises at the next edge and never rises otherwise. An `issue_i` pulse while busy changes nothing.
- R3: The opcode, invert-A, zero-A, immediate, immediate-valid and read-mask inputs are sampled only in the issue cycle. Their later values have no effect on the operation in flight.
- R4: The release of a required read port is high from the cycle after issue and stays high through any number of stall cycles until that port's go is sampled high.
- R5: The operand on a port's slice of `src_i` (port k at bits k*16 upward) is latched at the edge where that port's release and go are both high. The release is low in the following cycle. A go on a port whose release is low is ignored.
- R6: Read port 0 is skipped when zero-A is set. Read port 1 is skipped when immediate-valid is set. Port k is skipped when bit k of `rd_mask_n_i` is 1. A skipped port never raises its release, and its operand is taken as zero.
- R7: With opcode 1 (add), the result is A' + B' modulo 2^16. A' is 0 if zero-A is set, otherwise the bitwise inverse of operand A if invert-A is set, otherwise operand A. B' is the immediate if immediate-valid is set, otherwise operand B.
- R8: With any other opcode (0 is the no-op), the result is A', and operand B and the immediate are ignored.
- R9: `wr_rel_o` rises one cycle after the edge that latches the last required operand. When no port is required, it rises two cycles after the issue cycle.
- R10: `wr_rel_o` and `result_o` hold until `wr_go_i` is sampled high while `wr_rel_o` is high. In the next cycle both `busy_o` and `wr_rel_o` are low. A `wr_go_i` while `wr_rel_o` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Issue strobe |
| opc_i | input | 2 | Opcode: 1 add, otherwise pass A |
| inv_a_i | input | 1 | Invert operand A |
| zero_a_i | input | 1 | Force operand A to zero, skip port 0 |
| imm_i | input | 16 | Immediate value |
| imm_vld_i | input | 1 | Immediate replaces operand B, skip port 1 |
| rd_mask_n_i | input | 2 | Per-port skip mask, bit set skips the port |
| src_i | input | 32 | Operand data, port k in bits [16k+15:16k] |
| rd_go_i | input | 2 | Per-port read acknowledge |
| rd_rel_o | output | 2 | Per-port read request |
| wr_go_i | input | 1 | Write acknowledge |
| wr_rel_o | output | 1 | Write request |
| result_o | output | 16 | Result, valid while wr_rel_o is high |
| busy_o | output | 1 | Unit occupied |

## Verification
The bench sweeps every mix of opcode, invert, zero, immediate-valid and mask bits, with varied read and write stalls, and compares each result with a model computed arithmetically. Corner cases are targeted directly. The fields are scrambled right after issue, which exposes a design that samples them late. Go pulses are sent to skipped ports with junk data, which catches a design that latches operands it should ignore. An issue pulse during the write wait would overwrite the state in flight if it were accepted. An early write-go would end busy before the result existed. The timing of the write release is checked to the cycle, so a design that skips the result register or waits an extra cycle is reported.

// File: rtl/fu_issue_pkg.sv
package fu_issue_pkg;
  typedef enum logic [1:0] {
    OPC_NOP = 2'd0,
    OPC_ADD = 2'd1
  } opc_e;

  typedef struct packed {
    logic [1:0] opc;
    logic       inv_a;
    logic       zero_a;
    logic       imm_vld;
  } ctl_t;
endpackage

// File: rtl/fu_rd_port.sv
module fu_rd_port #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              need_i,
  input  logic              go_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              rel_o,
  output logic [DATA_W-1:0] opnd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_o  <= 1'b0;
      opnd_o <= '0;
    end else if (start_i) begin
      rel_o  <= need_i;
      opnd_o <= '0;
    end else if (rel_o && go_i) begin
      rel_o  <= 1'b0;
      opnd_o <= src_i;
    end
  end
endmodule

// File: rtl/fu_alu.sv
module fu_alu
  import fu_issue_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  ctl_t              ctl_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  logic [DATA_W-1:0] a_mod, b_mod;

  always_comb begin
    if (ctl_i.zero_a)     a_mod = '0;
    else if (ctl_i.inv_a) a_mod = ~a_i;
    else                  a_mod = a_i;
    b_mod = ctl_i.imm_vld ? imm_i : b_i;
    if (ctl_i.opc == OPC_ADD) y_o = a_mod + b_mod;
    else                      y_o = a_mod;
  end
endmodule

// File: rtl/fu_issue_mgr.sv
module fu_issue_mgr
  import fu_issue_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N_RD   = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   issue_i,
  input  logic [1:0]             opc_i,
  input  logic                   inv_a_i,
  input  logic                   zero_a_i,
  input  logic [DATA_W-1:0]      imm_i,
  input  logic                   imm_vld_i,
  input  logic [N_RD-1:0]        rd_mask_n_i,
  input  logic [N_RD*DATA_W-1:0] src_i,
  input  logic [N_RD-1:0]        rd_go_i,
  output logic [N_RD-1:0]        rd_rel_o,
  input  logic                   wr_go_i,
  output logic                   wr_rel_o,
  output logic [DATA_W-1:0]      result_o,
  output logic                   busy_o
);
  localparam int SRC_W = N_RD * DATA_W;

  logic              accept;
  ctl_t              ctl_q;
  logic [DATA_W-1:0] imm_q;
  logic [N_RD-1:0]   need;
  logic [DATA_W-1:0] opnd [N_RD];
  logic [DATA_W-1:0] alu_y;
  logic              busy_q, res_vld_q;
  logic [DATA_W-1:0] res_q;

  assign accept = issue_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      imm_q <= '0;
    end else if (accept) begin
      ctl_q <= '{opc: opc_i, inv_a: inv_a_i, zero_a: zero_a_i, imm_vld: imm_vld_i};
      imm_q <= imm_i;
    end
  end

  for (genvar k = 0; k < N_RD; k++) begin : g_rd
    logic skip;
    if (k == 0)      begin : g_a assign skip = zero_a_i;  end
    else if (k == 1) begin : g_b assign skip = imm_vld_i; end
    else             begin : g_n assign skip = 1'b0;      end
    assign need[k] = ~skip & ~rd_mask_n_i[k];

    fu_rd_port #(.DATA_W(DATA_W)) i_port (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(accept),
      .need_i (need[k]),
      .go_i   (rd_go_i[k]),
      .src_i  (src_i[k*DATA_W +: DATA_W]),
      .rel_o  (rd_rel_o[k]),
      .opnd_o (opnd[k])
    );
  end

  fu_alu #(.DATA_W(DATA_W)) i_alu (
    .ctl_i(ctl_q),
    .imm_i(imm_q),
    .a_i  (opnd[0]),
    .b_i  (opnd[1]),
    .y_o  (alu_y)
  );

  // result registers once no read is outstanding
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      res_vld_q <= 1'b0;
      res_q     <= '0;
    end else if (accept) begin
      busy_q    <= 1'b1;
      res_vld_q <= 1'b0;
    end else if (busy_q && !res_vld_q && !(|rd_rel_o)) begin
      res_vld_q <= 1'b1;
      res_q     <= alu_y;
    end else if (res_vld_q && wr_go_i) begin
      busy_q    <= 1'b0;
      res_vld_q <= 1'b0;
    end
  end

  assign busy_o   = busy_q;
  assign wr_rel_o = res_vld_q;
  assign result_o = res_q;

  logic unused_w;
  assign unused_w = ^SRC_W;
endmodule

// File: rtl/fu_issue_chk.sv
module fu_issue_chk #(
  parameter int DATA_W = 16,
  parameter int N_RD   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_i,
  input logic              busy_o,
  input logic [N_RD-1:0]   rd_go_i,
  input logic [N_RD-1:0]   rd_rel_o,
  input logic              wr_go_i,
  input logic              wr_rel_o,
  input logic [DATA_W-1:0] result_o
);
  p_busy_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(issue_i));

  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !(wr_rel_o && wr_go_i) |=> busy_o);

  p_busy_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rel_o && wr_go_i |=> !busy_o && !wr_rel_o);

  p_wr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rel_o && !wr_go_i |=> wr_rel_o && $stable(result_o));

  p_wr_after_reads_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rel_o |-> rd_rel_o == '0 && busy_o);

  for (genvar k = 0; k < N_RD; k++) begin : g_p
    p_rel_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rd_rel_o[k]) |-> $past(issue_i) && !$past(busy_o));
    p_rel_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_rel_o[k] && !rd_go_i[k] |=> rd_rel_o[k]);
    p_rel_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_rel_o[k] && rd_go_i[k] |=> !rd_rel_o[k]);
  end
endmodule

bind fu_issue_mgr fu_issue_chk #(.DATA_W(DATA_W), .N_RD(N_RD)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .issue_i (issue_i),
  .busy_o  (busy_o),
  .rd_go_i (rd_go_i),
  .rd_rel_o(rd_rel_o),
  .wr_go_i (wr_go_i),
  .wr_rel_o(wr_rel_o),
  .result_o(result_o)
);

// File: tb/test_fu_issue_mgr.sv
module test_fu_issue_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          issue_i = 1'b0;
  logic [1:0]    opc_i = '0;
  logic          inv_a_i = 1'b0, zero_a_i = 1'b0, imm_vld_i = 1'b0;
  logic [W-1:0]  imm_i = '0;
  logic [1:0]    rd_mask_n_i = '0;
  logic [2*W-1:0] src_i = '0;
  logic [1:0]    rd_go_i = '0;
  logic [1:0]    rd_rel_o;
  logic          wr_go_i = 1'b0;
  logic          wr_rel_o;
  logic [W-1:0]  result_o;
  logic          busy_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fu_issue_mgr #(.DATA_W(W), .N_RD(2)) i_fu_issue_mgr (
    .clk_i, .rst_ni, .issue_i, .opc_i, .inv_a_i, .zero_a_i, .imm_i, .imm_vld_i,
    .rd_mask_n_i, .src_i, .rd_go_i, .rd_rel_o, .wr_go_i, .wr_rel_o, .result_o, .busy_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [1:0] op, input logic inv, zero, immv,
      input logic [W-1:0] imm, input logic [1:0] need, input logic [W-1:0] a, b);
    logic [W-1:0] oa, ob, ma, mb;
    oa = need[0] ? a : '0;
    ob = need[1] ? b : '0;
    ma = zero ? '0 : (inv ? ~oa : oa);
    mb = immv ? imm : ob;
    return (op == 2'd1) ? W'(ma + mb) : ma;
  endfunction

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic run_op(input logic [1:0] op, input logic inv, zero, immv,
      input logic [W-1:0] imm, input logic [1:0] mask, input logic [W-1:0] a, b,
      input int d0, d1, dw);
    logic [1:0] need;
    logic [W-1:0] exp_y, held;
    int dl [2];
    dl[0] = d0; dl[1] = d1;
    need[0] = !mask[0] && !zero;
    need[1] = !mask[1] && !immv;
    exp_y = model(op, inv, zero, immv, imm, need, a, b);

    chk(busy_o == 1'b0, "R2 idle before issue", busy_o, 0);
    issue_i = 1'b1; opc_i = op; inv_a_i = inv; zero_a_i = zero;
    imm_vld_i = immv; imm_i = imm; rd_mask_n_i = mask;
    tick();
    issue_i = 1'b0; opc_i = ~op; inv_a_i = ~inv; zero_a_i = ~zero;
    imm_vld_i = ~immv; imm_i = ~imm; rd_mask_n_i = ~mask;  // R3 scramble
    chk(busy_o == 1'b1, "R2 busy after issue", busy_o, 1);
    chk(rd_rel_o == need, "R4/R6 release after issue", rd_rel_o, need);
    chk(wr_rel_o == 1'b0, "R9 no early write release", wr_rel_o, 0);

    // R5 go on idle ports, R10 early write-go: both ignored
    rd_go_i = ~need; src_i = 32'hbeef_dead; wr_go_i = 1'b1;
    tick();
    rd_go_i = '0; wr_go_i = 1'b0;
    chk(rd_rel_o == need, "R5 stray go ignored", rd_rel_o, need);
    chk(busy_o == 1'b1, "R10 early write-go ignored", busy_o, 1);

    for (int k = 0; k < 2; k++) begin
      if (need[k]) begin
        for (int s = 0; s < dl[k]; s++) begin
          tick();
          chk(rd_rel_o[k] == 1'b1, "R4 release held in stall", rd_rel_o[k], 1);
        end
        rd_go_i[k] = 1'b1;
        src_i[k*W +: W] = (k == 0) ? a : b;
        tick();
        rd_go_i[k] = 1'b0; src_i = 32'h5a5a_a5a5;
        chk(rd_rel_o[k] == 1'b0, "R5 release drops after go", rd_rel_o[k], 0);
      end
    end
    if (need != 2'b00) begin
      chk(wr_rel_o == 1'b0, "R9 write release waits one cycle", wr_rel_o, 0);
      tick();
    end
    chk(wr_rel_o == 1'b1, "R9 write release raised", wr_rel_o, 1);
    if (op == 2'd1) chk(result_o == exp_y, "R7 add result", result_o, exp_y);
    else            chk(result_o == exp_y, "R8 pass-through result", result_o, exp_y);
    held = result_o;

    for (int s = 0; s < dw; s++) begin
      if (s == 0) begin
        issue_i = 1'b1; opc_i = 2'd1; zero_a_i = 1'b0; imm_vld_i = 1'b0; rd_mask_n_i = 2'b00;
      end
      tick();
      issue_i = 1'b0;
      chk(wr_rel_o == 1'b1 && result_o == held, "R10 write release and result held",
          result_o, held);
      chk(rd_rel_o == 2'b00, "R2 issue while busy ignored", rd_rel_o, 0);
    end
    wr_go_i = 1'b1;
    tick();
    wr_go_i = 1'b0;
    chk(busy_o == 1'b0 && wr_rel_o == 1'b0, "R10 busy ends after write-go",
        {busy_o, wr_rel_o}, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog actual %0d expected below 100000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && rd_rel_o == 0 && wr_rel_o == 0 && result_o == 0,
        "R1 reset state", {busy_o, rd_rel_o, wr_rel_o, result_o}, 0);
    rst_ni = 1'b1;
    tick();
    chk(busy_o == 1'b0, "R2 no busy without issue", busy_o, 0);

    run_op(2'd1, 0, 0, 1, 16'd8, 2'b00, 16'd5, 16'd2, 0, 0, 0);  // 13
    run_op(2'd1, 0, 0, 0, 16'd0, 2'b00, 16'd5, 16'd2, 0, 0, 0);  // 7
    run_op(2'd1, 1, 0, 0, 16'd0, 2'b00, 16'd5, 16'd2, 0, 3, 1);  // 65532
    run_op(2'd1, 0, 1, 1, 16'd8, 2'b00, 16'd5, 16'd2, 0, 0, 0);  // 8
    run_op(2'd1, 0, 1, 0, 16'd0, 2'b00, 16'd5, 16'd2, 0, 0, 0);  // 2
    run_op(2'd0, 0, 0, 1, 16'd8, 2'b00, 16'd9, 16'd2, 0, 0, 0);  // 9
    run_op(2'd1, 0, 0, 0, 16'd8, 2'b01, 16'd5, 16'd2, 0, 0, 0);  // masked A: 2

    for (int cfg = 0; cfg < 64; cfg++) begin
      for (int rep = 0; rep < 2; rep++) begin
        logic [1:0] op;
        op = cfg[0] ? 2'd1 : (rep[0] ? 2'd3 : 2'd0);
        run_op(op, cfg[1], cfg[2], cfg[3], W'(cfg*1237 + 17), 2'(cfg >> 4),
               W'(cfg*40503 + rep*7 + 5), W'(cfg*911 + 65530 - rep),
               (cfg + rep) % 3, (cfg / 3 + rep) % 3, (cfg + rep) % 3);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule